// File: doc/BRIEF.md
# Programmable Address Window Decoder

This block holds a bank of address windows that software programs, and it uses them to route CPU physical addresses. Each window has four fields: an enable, a target ID, an attribute byte and a power-of-two size of at least 64 KiB. The window's base must be aligned to that size. A decode request carries a 36-bit address. The block answers in the same cycle with a hit flag, the target and attribute of the matching window, and an output address. When no enabled window matches, the block raises a miss flag instead.

The register map has two groups of windows. The lower group of windows can translate addresses. Each of these windows has a remap pair of registers that replaces the upper address bits covered by the window's size. The upper group has only control and base registers, and its windows pass the address through unchanged. A 16-byte reserved gap separates the two groups. The gap holds one stored sync-barrier word. When several windows cover the same address, the window with the smallest index wins.

Top module: `addr_win_decoder`

## Requirements
- R1: After reset, every register reads zero, including the sync-barrier word. Every decode request misses.
- R2: A window's control word stores all 32 bits and reads back unchanged. Bit 0 is the enable and bit 1 is a sync-barrier request. Bits 7:4 hold the target ID, bits 15:8 hold the attribute, and bits 31:16 hold the size minus one in 64 KiB units.
- R3: A window's base word keeps address bits 31:16 in its bits 31:16 and address bits 35:32 in its bits 3:0. Bits 15:4 read zero.
- R4: Window i below 8 sits at byte offset 0x10*i. Its control, base, remap-low and remap-high words follow at +0, +4, +8 and +0xC. Window j from 8 to 19 sits at 0x90 + 8*(j-8), with control at +0 and base at +4. Remap-low keeps only bits 31:16. Remap-high keeps all 32 bits.
- R5: Offset 0x84 is a 32-bit read/write sync-barrier word. The other gap offsets (0x80, 0x88, 0x8C) read zero. So do offsets from 0xF0 upward and offsets whose bits 1:0 are not zero. Writes to any of these offsets change no register.
- R6: An enabled window hits when two conditions hold. Address bits 35:16, with the size-minus-one bits masked off, must equal the window base. Address bits 35:32 must equal the stored upper base bits. On a hit, the outputs give the target and attribute of the window that wins.
- R7: A window whose enable bit is clear never hits. Writing zero to its control word disables it.
- R8: When several enabled windows hit, the one with the lowest index supplies target, attribute and output address.
- R9: A hit in windows 0 to 7 builds the output address from three parts. Bits 35:32 come from remap-high bits 3:0. Bits 31:16 come from remap-low bits 31:16 outside the size mask and from the address inside it. Bits 15:0 come from the address.
- R10: A hit in windows 8 to 19 outputs the input address unchanged.
- R11: With the request asserted, a decode that hits no window raises the miss flag, drops the hit flag, drives target and attribute to zero and outputs the input address. With the request low, both flags stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data at reg_addr (combinational) |
| dec_req | input | 1 | Decode request valid |
| dec_addr | input | 36 | Address to decode |
| dec_hit | output | 1 | Request matched an enabled window |
| dec_miss | output | 1 | Request matched no window |
| dec_tgt | output | 4 | Target ID of the winning window |
| dec_attr | output | 8 | Attribute of the winning window |
| dec_out | output | 36 | Translated or passed-through address |

## Verification
The bench uses the default parameters: twenty windows, eight of them remappable, 36-bit addresses and a 12-bit register offset. With these values both window groups, the gap at 0x80 and the first unmapped offset 0xF0 are all real addresses that the bench can reach. Overlap tests pair a remappable window with a pass-through one, so the priority result also shows up as a change in the output address. Size masks from 64 KiB to 256 MiB exercise both the boundary of the masked compare and the remap merge.

// File: rtl/awd_pkg.sv
package awd_pkg;

   // control word layout, MSB first
   typedef struct packed {
      logic [15:0] size_m1;
      logic [7:0]  attr;
      logic [3:0]  tgt;
      logic [1:0]  spare;
      logic        barrier;
      logic        en;
   } win_ctrl_t;

   localparam int unsigned RMP_STRIDE = 16;
   localparam int unsigned FIX_STRIDE = 8;
   localparam int unsigned GAP_BYTES  = 16;

   // byte offset of a window's first register; idx == count gives map end
   function automatic int unsigned win_byte_off(input int unsigned idx,
                                                input int unsigned n_remap);
      if (idx < n_remap)
         return idx * RMP_STRIDE;
      return n_remap * RMP_STRIDE + GAP_BYTES + (idx - n_remap) * FIX_STRIDE;
   endfunction

endpackage

// File: rtl/awd_prio_pick.sv
module awd_prio_pick #(
   parameter int unsigned N  = 20,
   parameter int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  req,
   output logic [N-1:0]  grant,
   output logic [IW-1:0] idx,
   output logic          any
);

   always_comb begin
      grant = '0;
      idx   = '0;
      for (int i = int'(N) - 1; i >= 0; i--) begin
         if (req[i]) begin
            grant    = '0;
            grant[i] = 1'b1;
            idx      = IW'(i);
         end
      end
   end

   assign any = |req;

   AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant)) else $error("more than one window granted"); // R8

   AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      any |-> (((grant - 1'b1) & req) == '0)) else $error("lower request skipped"); // R8

endmodule

// File: rtl/awd_window.sv
module awd_window
   import awd_pkg::*;
#(
   parameter int unsigned IDX       = 0,
   parameter int unsigned N_REMAP   = 8,
   parameter int unsigned ADDR_W    = 36,
   parameter int unsigned REG_AW    = 12,
   parameter bit          HAS_REMAP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_ok,
   input  logic              reg_we,
   input  logic [REG_AW-3:0] reg_word,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic [ADDR_W-1:0] dec_addr,
   output logic              match,
   output logic [3:0]        tgt,
   output logic [7:0]        attr,
   output logic [ADDR_W-1:0] xlat_addr
);

   localparam int unsigned HI_W   = ADDR_W - 32;
   localparam int unsigned WORD0  = win_byte_off(IDX, N_REMAP) / 4;
   localparam int unsigned N_REGS = HAS_REMAP ? 4 : 2;

   logic [3:0]        sel;
   win_ctrl_t         ctrl_q;
   logic [15:0]       base_lo_q;
   logic [HI_W-1:0]   base_hi_q;
   logic [15:0]       remap_lo_q;
   logic [31:0]       remap_hi_q;
   logic [15:0]       keep;

   for (genvar k = 0; k < 4; k++) begin : g_sel
      if (k < N_REGS) begin : g_real
         assign sel[k] = reg_ok && (reg_word == (REG_AW-2)'(WORD0 + k));
      end else begin : g_none
         assign sel[k] = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q    <= '0;
         base_lo_q <= '0;
         base_hi_q <= '0;
      end else if (reg_we) begin
         if (sel[0]) ctrl_q <= win_ctrl_t'(reg_wdata);
         if (sel[1]) begin
            base_lo_q <= reg_wdata[31:16];
            base_hi_q <= reg_wdata[HI_W-1:0];
         end
      end
   end

   assign keep  = ~ctrl_q.size_m1;
   assign match = ctrl_q.en
               && ((dec_addr[31:16] & keep) == base_lo_q)
               && (dec_addr[ADDR_W-1:32] == base_hi_q);
   assign tgt   = ctrl_q.tgt;
   assign attr  = ctrl_q.attr;

   if (HAS_REMAP) begin : g_remap
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            remap_lo_q <= '0;
            remap_hi_q <= '0;
         end else if (reg_we) begin
            if (sel[2]) remap_lo_q <= reg_wdata[31:16];
            if (sel[3]) remap_hi_q <= reg_wdata;
         end
      end
      assign xlat_addr = {remap_hi_q[HI_W-1:0],
                          (remap_lo_q & keep) | (dec_addr[31:16] & ctrl_q.size_m1),
                          dec_addr[15:0]};
   end else begin : g_plain
      assign remap_lo_q = '0;
      assign remap_hi_q = '0;
      assign xlat_addr  = dec_addr;
   end

   always_comb begin
      reg_rdata = '0;
      if (sel[0]) reg_rdata = ctrl_q;
      if (sel[1]) reg_rdata = {base_lo_q, 16'h0} | 32'(base_hi_q);
      if (sel[2]) reg_rdata = {remap_lo_q, 16'h0};
      if (sel[3]) reg_rdata = remap_hi_q;
   end

   AST_CTRL_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && sel[0]) |=> (ctrl_q == $past(reg_wdata))) else $error("ctrl write lost"); // R2

   AST_DISABLED_NO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_q.en |-> !match) else $error("disabled window matched"); // R7

   AST_ONE_REG_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel)) else $error("two registers selected"); // R4

endmodule

// File: rtl/addr_win_decoder.sv
module addr_win_decoder
   import awd_pkg::*;
#(
   parameter int unsigned NUM_WIN   = 20,
   parameter int unsigned NUM_REMAP = 8,
   parameter int unsigned ADDR_W    = 36,
   parameter int unsigned REG_AW    = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              dec_req,
   input  logic [ADDR_W-1:0] dec_addr,
   output logic              dec_hit,
   output logic              dec_miss,
   output logic [3:0]        dec_tgt,
   output logic [7:0]        dec_attr,
   output logic [ADDR_W-1:0] dec_out
);

   localparam int unsigned IW       = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;
   localparam int unsigned GAP_WORD = NUM_REMAP * RMP_STRIDE / 4;
   localparam int unsigned BAR_WORD = GAP_WORD + 1;
   localparam int unsigned MAP_END  = win_byte_off(NUM_WIN, NUM_REMAP);

   if (NUM_REMAP > NUM_WIN) begin : g_chk_remap
      $error("NUM_REMAP exceeds NUM_WIN");
   end
   if (ADDR_W < 33 || ADDR_W > 36) begin : g_chk_addr
      $error("ADDR_W must lie in 33..36");
   end
   if (MAP_END > (1 << REG_AW)) begin : g_chk_map
      $error("register map does not fit REG_AW");
   end

   logic              aligned;
   logic [REG_AW-3:0] word;
   logic              bar_sel;
   logic [31:0]       bar_q;
   logic [31:0]       w_rd    [NUM_WIN];
   logic [3:0]        w_tgt   [NUM_WIN];
   logic [7:0]        w_attr  [NUM_WIN];
   logic [ADDR_W-1:0] w_xlat  [NUM_WIN];
   logic [NUM_WIN-1:0] w_match;
   logic [NUM_WIN-1:0] grant;
   logic [IW-1:0]      pick;
   logic               any;

   assign aligned = (reg_addr[1:0] == 2'b00);
   assign word    = reg_addr[REG_AW-1:2];
   assign bar_sel = aligned && (word == (REG_AW-2)'(BAR_WORD));

   for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
      awd_window #(
         .IDX      (i),
         .N_REMAP  (NUM_REMAP),
         .ADDR_W   (ADDR_W),
         .REG_AW   (REG_AW),
         .HAS_REMAP(i < NUM_REMAP)
      ) i_win (
         .clk      (clk),
         .rst_n    (rst_n),
         .reg_ok   (aligned),
         .reg_we   (reg_we),
         .reg_word (word),
         .reg_wdata(reg_wdata),
         .reg_rdata(w_rd[i]),
         .dec_addr (dec_addr),
         .match    (w_match[i]),
         .tgt      (w_tgt[i]),
         .attr     (w_attr[i]),
         .xlat_addr(w_xlat[i])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 bar_q <= '0;
      else if (reg_we && bar_sel) bar_q <= reg_wdata;
   end

   always_comb begin
      reg_rdata = bar_sel ? bar_q : 32'h0;
      for (int i = 0; i < int'(NUM_WIN); i++) reg_rdata |= w_rd[i];
   end

   awd_prio_pick #(.N(NUM_WIN), .IW(IW)) i_pick (
      .clk  (clk),
      .rst_n(rst_n),
      .req  (w_match),
      .grant(grant),
      .idx  (pick),
      .any  (any)
   );

   always_comb begin
      dec_hit  = dec_req && any;
      dec_miss = dec_req && !any;
      dec_tgt  = '0;
      dec_attr = '0;
      dec_out  = dec_addr;
      if (dec_hit) begin
         dec_tgt  = w_tgt[pick];
         dec_attr = w_attr[pick];
         dec_out  = w_xlat[pick];
      end
   end

   AST_MISS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      dec_miss |-> (dec_tgt == '0 && dec_attr == '0 && dec_out == dec_addr)) else $error("dirty miss"); // R11

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_req |-> (!dec_hit && !dec_miss)) else $error("flag without request"); // R11

   AST_FIXED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_hit && (32'(pick) >= NUM_REMAP)) |-> (dec_out == dec_addr)) else $error("upper window altered address"); // R10

   AST_GAP_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (aligned && word >= (REG_AW-2)'(GAP_WORD) && word < (REG_AW-2)'(GAP_WORD + 4) && !bar_sel)
         |-> (reg_rdata == '0)) else $error("gap read nonzero"); // R5

   AST_BARRIER_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && bar_sel) |=> (bar_q == $past(reg_wdata))) else $error("barrier write lost"); // R5

endmodule

// File: tb/test_addr_win_decoder.sv
module test_addr_win_decoder;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        dec_req = 1'b0;
   logic [35:0] dec_addr = '0;
   logic        dec_hit, dec_miss;
   logic [3:0]  dec_tgt;
   logic [7:0]  dec_attr;
   logic [35:0] dec_out;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   addr_win_decoder i_addr_win_decoder (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dec_req(dec_req),
      .dec_addr(dec_addr), .dec_hit(dec_hit), .dec_miss(dec_miss),
      .dec_tgt(dec_tgt), .dec_attr(dec_attr), .dec_out(dec_out)
   );

   function automatic logic [11:0] woff(input int w);
      if (w < 8) return 12'(16 * w);
      return 12'(12'h90 + 8 * (w - 8));
   endfunction

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
      @(negedge clk);
      reg_addr = a;
      #2;
      check(tag, reg_rdata, exp);
   endtask

   task automatic dec_chk(input string tag, input logic [35:0] a, input bit hit,
                          input logic [3:0] t, input logic [7:0] at, input logic [35:0] o);
      @(negedge clk);
      dec_req = 1'b1; dec_addr = a;
      #2;
      check({tag, " hit"},  dec_hit,  hit);
      check({tag, " miss"}, dec_miss, !hit);
      check({tag, " tgt"},  dec_tgt,  t);
      check({tag, " attr"}, dec_attr, at);
      check({tag, " out"},  dec_out,  o);
      dec_req = 1'b0;
   endtask

   task automatic clear_all();
      for (int w = 0; w < 20; w++) begin
         wr(woff(w), 32'h0);
         wr(woff(w) + 12'h4, 32'h0);
         if (w < 8) begin
            wr(woff(w) + 12'h8, 32'h0);
            wr(woff(w) + 12'hC, 32'h0);
         end
      end
   endtask

   task automatic t_reset();
      rd_chk("R1 w0 ctrl", 12'h000, 32'h0);
      rd_chk("R1 w7 rhi", 12'h07C, 32'h0);
      rd_chk("R1 barrier", 12'h084, 32'h0);
      rd_chk("R1 w19 base", 12'h0EC, 32'h0);
      dec_chk("R1 R11 miss after reset", 36'h0_0000_0000, 1'b0, 4'h0, 8'h00, 36'h0_0000_0000);
   endtask

   task automatic t_layout();
      wr(12'h000, 32'h0003_C2A3);
      rd_chk("R2 ctrl readback", 12'h000, 32'h0003_C2A3);
      wr(12'h004, 32'hABCD_1237);
      rd_chk("R3 base masked", 12'h004, 32'hABCD_0007);
      wr(12'h070, 32'h1111_0000);
      wr(12'h078, 32'h1234_5678);
      wr(12'h07C, 32'h2222_2222);
      wr(12'h090, 32'h3333_0000);
      wr(12'h098, 32'h4444_0000);
      wr(12'h0EC, 32'hFFFF_FFFF);
      rd_chk("R4 w7 ctrl", 12'h070, 32'h1111_0000);
      rd_chk("R4 w7 remap lo", 12'h078, 32'h1234_0000);
      rd_chk("R4 w7 remap hi", 12'h07C, 32'h2222_2222);
      rd_chk("R4 w8 ctrl", 12'h090, 32'h3333_0000);
      rd_chk("R4 w9 ctrl", 12'h098, 32'h4444_0000);
      rd_chk("R4 w19 base", 12'h0EC, 32'hFFFF_000F);
      clear_all();
      rd_chk("R7 cleared ctrl", 12'h000, 32'h0);
   endtask

   task automatic t_gap();
      wr(12'h084, 32'h0000_FFFF);
      rd_chk("R5 barrier", 12'h084, 32'h0000_FFFF);
      wr(12'h080, 32'hDEAD_BEEF);
      rd_chk("R5 gap 80", 12'h080, 32'h0);
      rd_chk("R5 gap 88", 12'h088, 32'h0);
      rd_chk("R5 gap 8C", 12'h08C, 32'h0);
      wr(12'h0F0, 32'h1234_5678);
      rd_chk("R5 past end", 12'h0F0, 32'h0);
      wr(12'h091, 32'h5555_0000);
      rd_chk("R5 misaligned read", 12'h091, 32'h0);
      rd_chk("R5 w8 ctrl untouched", 12'h090, 32'h0);
      rd_chk("R5 w7 rhi untouched", 12'h07C, 32'h0);
      rd_chk("R5 w19 base untouched", 12'h0EC, 32'h0);
      rd_chk("R5 barrier kept", 12'h084, 32'h0000_FFFF);
   endtask

   task automatic t_match();
      // window 10: base 0x3_4000_0000, 1 MiB, tgt 3 attr 0x5A
      wr(12'h0A4, 32'h4000_0003);
      wr(12'h0A0, 32'h000F_5A31);
      dec_chk("R6 R10 low edge", 36'h3_4000_0000, 1'b1, 4'h3, 8'h5A, 36'h3_4000_0000);
      dec_chk("R6 R10 top edge", 36'h3_400F_FFFF, 1'b1, 4'h3, 8'h5A, 36'h3_400F_FFFF);
      dec_chk("R6 R11 above", 36'h3_4010_0000, 1'b0, 4'h0, 8'h00, 36'h3_4010_0000);
      dec_chk("R6 R11 upper bits", 36'h2_4000_0000, 1'b0, 4'h0, 8'h00, 36'h2_4000_0000);
      @(negedge clk);
      dec_req = 1'b0; dec_addr = 36'h3_4000_1000;
      #2;
      check("R11 idle hit", dec_hit, 1'b0);
      check("R11 idle miss", dec_miss, 1'b0);
      wr(12'h0A0, 32'h000F_5A30);
      dec_chk("R7 enable clear", 36'h3_4000_1000, 1'b0, 4'h0, 8'h00, 36'h3_4000_1000);
      wr(12'h0A0, 32'h000F_5A31);
      dec_chk("R7 reenabled", 36'h3_4000_1000, 1'b1, 4'h3, 8'h5A, 36'h3_4000_1000);
      wr(12'h0A0, 32'h0);
      wr(12'h0A4, 32'h0);
      dec_chk("R7 zeroed", 36'h3_4000_1000, 1'b0, 4'h0, 8'h00, 36'h3_4000_1000);
   endtask

   task automatic t_priority();
      // window 12: 64 KiB at 0x1_0000_0000, tgt C attr 12
      wr(12'h0B4, 32'h0000_0001);
      wr(12'h0B0, 32'h0000_12C1);
      // window 3: 16 MiB at 0x1_0000_0000, remap to 0x0_8000_0000, tgt 3 attr 33
      wr(12'h034, 32'h0000_0001);
      wr(12'h038, 32'h8000_0000);
      wr(12'h030, 32'h00FF_3331);
      dec_chk("R8 R9 overlap low wins", 36'h1_0000_1234, 1'b1, 4'h3, 8'h33, 36'h0_8000_1234);
      dec_chk("R9 only w3", 36'h1_0050_0000, 1'b1, 4'h3, 8'h33, 36'h0_8050_0000);
      wr(12'h030, 32'h0);
      dec_chk("R8 R10 w12 after w3 off", 36'h1_0000_1234, 1'b1, 4'hC, 8'h12, 36'h1_0000_1234);
      dec_chk("R6 w12 edge", 36'h1_0001_0000, 1'b0, 4'h0, 8'h00, 36'h1_0001_0000);
   endtask

   task automatic t_remap();
      // window 5: 256 MiB at 0x0_F000_0000 -> 0x9_2000_0000
      wr(12'h054, 32'hF000_0000);
      wr(12'h058, 32'h2000_0000);
      wr(12'h05C, 32'h0000_0009);
      wr(12'h050, 32'h0FFF_0173);
      dec_chk("R9 remap merge", 36'h0_F123_4567, 1'b1, 4'h7, 8'h01, 36'h9_2123_4567);
      dec_chk("R9 remap top", 36'h0_FFFF_FFFF, 1'b1, 4'h7, 8'h01, 36'h9_2FFF_FFFF);
      // window 19: 64 KiB at 0xA_BCDE_0000, pass through
      wr(12'h0EC, 32'hBCDE_000A);
      wr(12'h0E8, 32'h0000_77F1);
      dec_chk("R10 w19 pass", 36'hA_BCDE_4321, 1'b1, 4'hF, 8'h77, 36'hA_BCDE_4321);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_layout();
      t_gap();
      t_match();
      t_priority();
      t_remap();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule